// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Bank

This block stores the digital codes for a bank of twenty output channels: eighteen gamma reference levels and two common-voltage levels. Each code is ten bits wide. A serial-interface front end decodes bus traffic into simple write commands. Each command carries a channel number, a code and a load-mode flag. The bank keeps two registers per channel. The staging register receives every accepted write. The live register drives the channel's DAC.

A write in immediate mode reaches both registers on the same clock edge. A write in deferred mode fills only the staging register. Several deferred writes can then be committed together by a single global-load strobe, which copies every staging register into its live register on one edge. This lets a whole gamma curve switch at once.

Synchronous reset sets both registers of every channel to a default value. The same happens on the restore strobe, which the interface raises after a general-call reset or after its own device address is received. A channel's default is its stored non-volatile code when that channel's programmed bit is set. Otherwise the default is mid-scale, 10'h200. Programming of the non-volatile memory and the analog converters are outside this block.

Top module: `dac_bank_top`

## Requirements
- R1: There are 20 channels, each 10 bits wide. Channel i's live code appears on act_codes_o[10*i+9 : 10*i], and channel i's stored code is read from otp_code_i[10*i+9 : 10*i].
- R2: When rst_n is low at a rising clock edge, both registers of channel i load otp_code_i[10*i+9 : 10*i] if otp_valid_i[i] is 1, or 10'h200 if it is 0. err_o is 0 after that edge.
- R3: When restore_i is high at an edge, every channel reloads its R2 default into both registers. This overrides any write or global load presented on the same edge.
- R4: A write (wr_en_i=1, wr_chan_i<20) with wr_defer_i=0 puts wr_code_i into both registers of that channel at the same edge, so act_codes_o shows it right after that edge.
- R5: A write with wr_defer_i=1 changes only the staging register. The live code of that channel is unchanged until a later global load.
- R6: gload_i high at an edge copies all 20 staging registers to the live registers on that edge. A write on the same edge lands in the staging register first, so its code is what gets copied.
- R7: A write with wr_chan_i of 20 or more changes no register. err_o is 1 for the cycle after that edge, and 0 after any edge without such a write.
- R8: act_codes_o changes only on an edge where reset, restore, a valid write or a global load is applied. It holds its value on idle edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads channel defaults |
| restore_i | input | 1 | Strobe that reloads every channel's default |
| otp_code_i | input | 200 | Stored non-volatile codes, 10 bits per channel |
| otp_valid_i | input | 20 | Per-channel programmed flag for the stored code |
| wr_en_i | input | 1 | Write command valid |
| wr_chan_i | input | 5 | Target channel of the write |
| wr_code_i | input | 10 | Code carried by the write |
| wr_defer_i | input | 1 | 0: commit to live register now, 1: staging register only |
| gload_i | input | 1 | Global load of all staging registers into live registers |
| act_codes_o | output | 200 | Live codes of all channels |
| err_o | output | 1 | One-cycle flag for a write to a nonexistent channel |

## Verification
The bench targets several corner cases:
- Reset with a mix of programmed and unprogrammed channels. A bank that ignored the programmed flag would show a stored code where 10'h200 belongs, or the reverse.
- A deferred write followed by an idle edge. Logic that leaked staging data into the live register would change the output early.
- A global load and a deferred write on the same edge. A design that copied the stale staging value would miss the new code.
- A restore colliding with a write, and writes to channels 20 to 31. A restore that lost to the write, or an out-of-range write that aliased onto a real channel or left err_o stuck high, would each show up on the output bus.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
    parameter int unsigned DEF_NUM_CH = 20;
    parameter int unsigned DEF_CODE_W = 10;

    typedef enum logic {
        LOAD_NOW   = 1'b0,
        LOAD_LATER = 1'b1
    } load_mode_e;
endpackage

// File: rtl/dac_bank_wdec.sv
module dac_bank_wdec #(
    parameter int unsigned NUM_CH = dac_bank_pkg::DEF_NUM_CH,
    localparam int unsigned CHAN_W = $clog2(NUM_CH)
) (
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    output logic [NUM_CH-1:0] hit,
    output logic              bad
);
    localparam logic [CHAN_W:0] LIMIT = (CHAN_W+1)'(NUM_CH);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_chan == CHAN_W'(g));
    end

    assign bad = wr_en && ({1'b0, wr_chan} >= LIMIT);
endmodule

// File: rtl/dac_bank_chan.sv
module dac_bank_chan #(
    parameter int unsigned CODE_W = dac_bank_pkg::DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic [CODE_W-1:0] otp_code,
    input  logic              otp_valid,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_defer,
    input  logic              gload,
    output logic [CODE_W-1:0] pre_code,
    output logic [CODE_W-1:0] act_code
);
    import dac_bank_pkg::*;

    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        logic [CODE_W-1:0] pre;
        logic [CODE_W-1:0] act;
    } chan_regs_t;

    chan_regs_t        regs_d, regs_q;
    logic [CODE_W-1:0] dflt_code;
    load_mode_e        mode;

    assign dflt_code = otp_valid ? otp_code : MID_CODE;
    assign mode      = load_mode_e'(wr_defer);

    always_comb begin
        regs_d = regs_q;
        if (!rst_n || restore) begin
            regs_d.pre = dflt_code;
            regs_d.act = dflt_code;
        end else begin
            if (wr_hit) begin
                regs_d.pre = wr_code;
                if (mode == LOAD_NOW) begin
                    regs_d.act = wr_code;
                end
            end
            if (gload) begin
                regs_d.act = regs_d.pre;
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign pre_code = regs_q.pre;
    assign act_code = regs_q.act;
endmodule

// File: rtl/dac_bank_top.sv
module dac_bank_top #(
    parameter int unsigned NUM_CH = dac_bank_pkg::DEF_NUM_CH,
    parameter int unsigned CODE_W = dac_bank_pkg::DEF_CODE_W,
    localparam int unsigned CHAN_W = $clog2(NUM_CH),
    localparam int unsigned BUS_W  = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore_i,
    input  logic [BUS_W-1:0]  otp_code_i,
    input  logic [NUM_CH-1:0] otp_valid_i,
    input  logic              wr_en_i,
    input  logic [CHAN_W-1:0] wr_chan_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic              wr_defer_i,
    input  logic              gload_i,
    output logic [BUS_W-1:0]  act_codes_o,
    output logic              err_o
);
    typedef struct packed {
        logic err;
    } top_regs_t;

    top_regs_t         top_d, top_q;
    logic [NUM_CH-1:0] wr_hit;
    logic              wr_bad;
    logic [BUS_W-1:0]  pre_all;

    dac_bank_wdec #(.NUM_CH(NUM_CH)) u_wdec (
        .wr_en   (wr_en_i),
        .wr_chan (wr_chan_i),
        .hit     (wr_hit),
        .bad     (wr_bad)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dac_bank_chan #(.CODE_W(CODE_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .restore   (restore_i),
            .otp_code  (otp_code_i[c*CODE_W +: CODE_W]),
            .otp_valid (otp_valid_i[c]),
            .wr_hit    (wr_hit[c]),
            .wr_code   (wr_code_i),
            .wr_defer  (wr_defer_i),
            .gload     (gload_i),
            .pre_code  (pre_all[c*CODE_W +: CODE_W]),
            .act_code  (act_codes_o[c*CODE_W +: CODE_W])
        );
    end

    always_comb begin
        top_d     = top_q;
        top_d.err = rst_n && wr_bad;
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    assign err_o = top_q.err;
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
    parameter int unsigned NUM_CH = dac_bank_pkg::DEF_NUM_CH,
    parameter int unsigned CODE_W = dac_bank_pkg::DEF_CODE_W,
    localparam int unsigned CHAN_W = $clog2(NUM_CH),
    localparam int unsigned BUS_W  = NUM_CH * CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restore_i,
    input logic [BUS_W-1:0]  otp_code_i,
    input logic [NUM_CH-1:0] otp_valid_i,
    input logic              wr_en_i,
    input logic [CHAN_W-1:0] wr_chan_i,
    input logic [CODE_W-1:0] wr_code_i,
    input logic              wr_defer_i,
    input logic              gload_i,
    input logic [BUS_W-1:0]  act_codes_o,
    input logic              err_o,
    input logic [NUM_CH-1:0] wr_hit,
    input logic [BUS_W-1:0]  pre_all
);
    function automatic logic [CODE_W-1:0] fld(input logic [BUS_W-1:0] v, input int idx);
        return v[idx*CODE_W +: CODE_W];
    endfunction

    function automatic logic [BUS_W-1:0] dflt_vec(input logic [BUS_W-1:0] otp,
                                                  input logic [NUM_CH-1:0] vld);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < NUM_CH; i++) begin
            r[i*CODE_W +: CODE_W] = vld[i] ? otp[i*CODE_W +: CODE_W]
                                           : (CODE_W'(1) << (CODE_W - 1));
        end
        return r;
    endfunction

    // R1 R7: the decoder never selects more than one channel
    assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));

    assert_restore_defaults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(restore_i))
        |-> act_codes_o == dflt_vec($past(otp_code_i), $past(otp_valid_i)));

    assert_write_now_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && !$past(wr_defer_i) && !$past(restore_i)
         && (int'($past(wr_chan_i)) < NUM_CH))
        |-> fld(act_codes_o, int'($past(wr_chan_i))) == $past(wr_code_i));

    assert_write_later_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && $past(wr_defer_i) && !$past(restore_i)
         && !$past(gload_i) && (int'($past(wr_chan_i)) < NUM_CH))
        |-> fld(act_codes_o, int'($past(wr_chan_i)))
            == fld($past(act_codes_o), int'($past(wr_chan_i))));

    assert_gload_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gload_i) && !$past(restore_i) && !$past(wr_en_i))
        |-> act_codes_o == $past(pre_all));

    assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en_i) && (int'($past(wr_chan_i)) >= NUM_CH))
        |-> err_o);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(wr_en_i) && (int'($past(wr_chan_i)) >= NUM_CH)));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(restore_i) && !$past(gload_i)
         && !($past(wr_en_i) && (int'($past(wr_chan_i)) < NUM_CH)))
        |-> $stable(act_codes_o));
endmodule

bind dac_bank_top dac_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_i   (restore_i),
    .otp_code_i  (otp_code_i),
    .otp_valid_i (otp_valid_i),
    .wr_en_i     (wr_en_i),
    .wr_chan_i   (wr_chan_i),
    .wr_code_i   (wr_code_i),
    .wr_defer_i  (wr_defer_i),
    .gload_i     (gload_i),
    .act_codes_o (act_codes_o),
    .err_o       (err_o),
    .wr_hit      (wr_hit),
    .pre_all     (pre_all)
);

// File: tb/dac_bank_top_tb.sv
module dac_bank_top_tb;
    localparam int NCH = 20;
    localparam int CW  = 10;
    localparam int BW  = NCH * CW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            restore_i;
    logic [BW-1:0]   otp_code_i;
    logic [NCH-1:0]  otp_valid_i;
    logic            wr_en_i;
    logic [4:0]      wr_chan_i;
    logic [CW-1:0]   wr_code_i;
    logic            wr_defer_i;
    logic            gload_i;
    logic [BW-1:0]   act_codes_o;
    logic            err_o;

    logic [CW-1:0] exp_pre [NCH];
    logic [CW-1:0] exp_act [NCH];
    logic          exp_err;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done  = 0;

    always #4 clk = ~clk;

    dac_bank_top u_dut (
        .clk(clk), .rst_n(rst_n), .restore_i(restore_i),
        .otp_code_i(otp_code_i), .otp_valid_i(otp_valid_i),
        .wr_en_i(wr_en_i), .wr_chan_i(wr_chan_i), .wr_code_i(wr_code_i),
        .wr_defer_i(wr_defer_i), .gload_i(gload_i),
        .act_codes_o(act_codes_o), .err_o(err_o)
    );

    function automatic logic [CW-1:0] dflt(input int i);
        return otp_valid_i[i] ? otp_code_i[i*CW +: CW] : 10'h200;
    endfunction

    function automatic logic [BW-1:0] exp_bus();
        logic [BW-1:0] r;
        for (int i = 0; i < NCH; i++) r[i*CW +: CW] = exp_act[i];
        return r;
    endfunction

    task automatic load_defaults();
        for (int i = 0; i < NCH; i++) begin
            exp_pre[i] = dflt(i);
            exp_act[i] = dflt(i);
        end
    endtask

    task automatic check_all(input string req);
        n_cmp++;
        if (act_codes_o !== exp_bus()) begin
            n_bad++;
            $display("FAIL %s: act_codes_o got %h expected %h", req, act_codes_o, exp_bus());
        end
        n_cmp++;
        if (err_o !== exp_err) begin
            n_bad++;
            $display("FAIL %s: err_o got %b expected %b", req, err_o, exp_err);
        end
    endtask

    task automatic idle_inputs();
        restore_i = 0; wr_en_i = 0; wr_chan_i = 0; wr_code_i = 0;
        wr_defer_i = 0; gload_i = 0;
    endtask

    // One command cycle followed by one idle cycle (idle checks R8 and R7 pulse end)
    task automatic step(input logic we, input int ch, input logic [CW-1:0] code,
                        input logic dfr, input logic gl, input logic rs, input string req);
        @(negedge clk);
        wr_en_i = we; wr_chan_i = 5'(ch); wr_code_i = code;
        wr_defer_i = dfr; gload_i = gl; restore_i = rs;
        @(posedge clk);
        exp_err = we && (ch >= NCH);
        if (rs) begin
            load_defaults();
        end else begin
            if (we && ch < NCH) begin
                exp_pre[ch] = code;
                if (!dfr) exp_act[ch] = code;
            end
            if (gl) for (int i = 0; i < NCH; i++) exp_act[i] = exp_pre[i];
        end
        #2;
        check_all(req);
        @(negedge clk);
        idle_inputs();
        @(posedge clk);
        exp_err = 0;
        #2;
        check_all("R8 idle hold / R7 pulse end");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20820));
        idle_inputs();
        rst_n = 0;
        otp_valid_i = 20'b1011_0110_0101_1100_1001;
        for (int i = 0; i < NCH; i++) otp_code_i[i*CW +: CW] = CW'(37 * i + 5);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        load_defaults();
        exp_err = 0;
        @(posedge clk); #2;
        // R1 R2: per-channel reset value check
        for (int i = 0; i < NCH; i++) begin
            n_cmp++;
            if (act_codes_o[i*CW +: CW] !== exp_act[i]) begin
                n_bad++;
                $display("FAIL R2/R1 ch%0d: got %h expected %h", i, act_codes_o[i*CW +: CW], exp_act[i]);
            end
        end
        check_all("R2 reset state");

        step(1, 3, 10'h155, 0, 0, 0, "R4 immediate write");
        step(1, 19, 10'h3FF, 0, 0, 0, "R4 immediate write last channel");
        step(1, 0, 10'h001, 1, 0, 0, "R5 deferred write");
        step(1, 7, 10'h2AA, 1, 0, 0, "R5 deferred write second");
        step(0, 0, 10'h000, 0, 1, 0, "R6 global load");
        step(1, 12, 10'h0F0, 1, 1, 0, "R6 global load with same-cycle write");
        step(1, 20, 10'h111, 0, 0, 0, "R7 channel 20 ignored");
        step(1, 31, 10'h222, 0, 1, 0, "R7 channel 31 ignored with load");
        for (int i = 0; i < NCH; i++) otp_code_i[i*CW +: CW] = CW'(900 - 11 * i);
        otp_valid_i = ~otp_valid_i;
        step(1, 5, 10'h0AB, 0, 1, 1, "R3 restore overrides write and load");
        step(1, 2, 10'h3C3, 1, 0, 0, "R5 deferred after restore");
        step(0, 0, 10'h000, 0, 0, 1, "R3 restore drops staged data");
        step(0, 0, 10'h000, 0, 1, 0, "R6 load after restore keeps defaults");

        for (int k = 0; k < 400; k++) begin
            logic [3:0] r = 4'($urandom_range(0, 15));
            step(r != 0, int'($urandom_range(0, 31)), CW'($urandom),
                 1'($urandom), r[3:1] == 3'b111, r == 4'h5, "R4 R5 R6 R7 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule